// File: doc/BRIEF.md
# Fast Page Mode DRAM Access Controller

This block sits between a synchronous request stream and a 1M x 16 asynchronous DRAM with a multiplexed address bus. Each request carries a 20-bit word address, a write flag, two byte enables and 16 bits of write data. The controller turns it into a row strobe phase and a column strobe phase. The upper ten address bits go out as the row while the row strobe falls, and the lower ten bits go out as the column while the column strobes fall. Each byte lane has its own column strobe, so byte writes and byte reads need no extra cycle.

An open row stays active between requests. A request to the same row costs only a new column cycle, with the row strobe held low. A request to another row first precharges and then opens the new row. The page is also closed before the row strobe's maximum low time can run out, and when the refresh scheduler raises its request. Writes use early-write timing, so the device never drives its data pins during a write. Read data is sampled at the end of the column strobe pulse and returned with a one-cycle valid pulse.

Requests use valid/ready. A request is taken on a clock edge where both are high. Only one request is in flight at a time. Ready is low while an access or a precharge is running, and while refresh is requested. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take. Read responses come back in request order.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, the row strobe, both column strobes, write enable and output enable are high, the data bus is not driven, `req_ready` and `rsp_valid` are low. `req_ready` rises only after the row strobe has been high for the precharge count.
- R2: `req_addr[19:10]` is on `dram_addr` in the cycle the row strobe falls. `req_addr[9:0]` is on `dram_addr` in the cycle the column strobes fall.
- R3: `req_be[0]` enables the lower strobe (data bits 7:0) and `req_be[1]` enables the upper strobe (bits 15:8). A lane whose strobe stays high keeps its stored byte on a write.
- R4: For a write, write enable is low at least one cycle before the column strobes fall, output enable stays high, and the controller drives the write data. For a read, the controller never drives the data bus.
- R5: The column strobes fall no earlier than T_RCD_CYC+1 cycles after the row strobe falls. They stay low T_CAS_CYC cycles. Within a page, both are high at least T_CP_CYC cycles between column cycles. The row strobe stays high at least T_RP_CYC cycles before a row is opened.
- R6: A read returns `rsp_valid` as a one-cycle pulse. `rsp_rdata` holds the bus value sampled in the last strobe-low cycle, with bytes of disabled lanes forced to zero.
- R7: A request to the open row reuses it. The row strobe stays low and only a column cycle is issued.
- R8: A request to a different row raises the row strobe, precharges, and then opens the new row.
- R9: The row strobe is never low for more than RAS_MAX_CYC consecutive cycles. A long run of same-row requests is split by page closures.
- R10: While `ref_req` is high, `req_ready` is low and the open page is closed. `ref_gnt` is high only while the row strobe has been precharged and all strobes are high with the data bus released.
- R11: Requests are taken only on edges with valid and ready both high. Read responses arrive in request order with the data of the latest write to each address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 20 | Word address, row in upper half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh scheduler wants the bus |
| ref_gnt | output | 1 | Bus released to the refresh scheduler |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the device |

## Verification
The bench builds the controller with T_RP_CYC=3, T_RCD_CYC=2, T_CAS_CYC=2, T_CP_CYC=1 and RAS_MAX_CYC=40. The short row-strobe limit lets a stream of about a dozen same-row reads reach the forced page closure, which the default limit of ten thousand cycles would keep out of reach. With short precharge and strobe counts, page hits, page misses, byte-lane merges and a refresh grant all fit in a few hundred cycles. A pin-level model of the device in the bench latches row and column on the strobe edges, so an address or lane error shows up as wrong read data as well as a pin-timing mismatch.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    S_PRE  = 3'd0,
    S_IDLE = 3'd1,
    S_ACT  = 3'd2,
    S_CSET = 3'd3,
    S_CAS  = 3'd4,
    S_CPRE = 3'd5,
    S_OPEN = 3'd6
  } fpm_state_e;
endpackage

// File: rtl/fpm_page_track.sv
module fpm_page_track #(
  parameter int ROW_W       = 10,
  parameter int RAS_MAX_CYC = 10000,
  parameter int MARGIN_CYC  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_low,
  input  logic             load,
  input  logic [ROW_W-1:0] new_row,
  output logic [ROW_W-1:0] open_row,
  output logic             close_page
);
  localparam int AGE_W    = $clog2(RAS_MAX_CYC + 1);
  localparam int CLOSE_AT = RAS_MAX_CYC - MARGIN_CYC;

  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row <= '0;
    end else if (load) begin
      open_row <= new_row;
    end
  end

  // age counts the row-strobe-low cycles before the current one
  always_ff @(posedge clk) begin
    if (!rst_n || !ras_low) begin
      age <= '0;
    end else if (age != AGE_W'(RAS_MAX_CYC)) begin
      age <= age + 1'b1;
    end
  end

  assign close_page = ras_low && (age >= AGE_W'(CLOSE_AT));

  // R9: row strobe low time bounded
  a_r9_ras_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (age < AGE_W'(RAS_MAX_CYC)));
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int T_RP_CYC  = 5,
  parameter int T_RCD_CYC = 2,
  parameter int T_CAS_CYC = 2,
  parameter int T_CP_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       row_hit,
  input  logic       close_page,
  input  logic       ref_req,
  output fpm_state_e st,
  output logic       req_ready,
  output logic       accept,
  output logic       cas_last,
  output logic       ref_gnt
);
  localparam int M1      = (T_RP_CYC > T_RCD_CYC) ? T_RP_CYC : T_RCD_CYC;
  localparam int M2      = (T_CAS_CYC > T_CP_CYC) ? T_CAS_CYC : T_CP_CYC;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CW      = $clog2(CNT_MAX + 1);

  fpm_state_e nxt;
  logic [CW-1:0] cnt, nxt_cnt;
  logic pend, nxt_pend;

  assign req_ready = !ref_req &&
                     ((st == S_IDLE) || ((st == S_OPEN) && !close_page));
  assign accept    = req_valid && req_ready;
  assign cas_last  = (st == S_CAS) && (cnt == '0);
  assign ref_gnt   = ref_req && (st == S_IDLE);

  always_comb begin
    nxt      = st;
    nxt_cnt  = cnt;
    nxt_pend = pend;
    case (st)
      S_PRE: begin
        if (cnt == '0) begin
          nxt      = pend ? S_ACT : S_IDLE;
          nxt_cnt  = CW'(T_RCD_CYC - 1);
          nxt_pend = 1'b0;
        end else begin
          nxt_cnt = cnt - 1'b1;
        end
      end
      S_IDLE: begin
        if (accept) begin
          nxt     = S_ACT;
          nxt_cnt = CW'(T_RCD_CYC - 1);
        end
      end
      S_ACT: begin
        if (cnt == '0) nxt = S_CSET;
        else           nxt_cnt = cnt - 1'b1;
      end
      S_CSET: begin
        nxt     = S_CAS;
        nxt_cnt = CW'(T_CAS_CYC - 1);
      end
      S_CAS: begin
        if (cnt == '0) begin
          nxt     = S_CPRE;
          nxt_cnt = CW'(T_CP_CYC - 1);
        end else begin
          nxt_cnt = cnt - 1'b1;
        end
      end
      S_CPRE: begin
        if (cnt == '0) nxt = S_OPEN;
        else           nxt_cnt = cnt - 1'b1;
      end
      S_OPEN: begin
        if (ref_req || close_page) begin
          nxt     = S_PRE;
          nxt_cnt = CW'(T_RP_CYC - 1);
        end else if (accept) begin
          if (row_hit) begin
            nxt = S_CSET;
          end else begin
            nxt      = S_PRE;
            nxt_cnt  = CW'(T_RP_CYC - 1);
            nxt_pend = 1'b1;
          end
        end
      end
      default: begin
        nxt     = S_PRE;
        nxt_cnt = CW'(T_RP_CYC - 1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_PRE;
      cnt  <= CW'(T_RP_CYC - 1);
      pend <= 1'b0;
    end else begin
      st   <= nxt;
      cnt  <= nxt_cnt;
      pend <= nxt_pend;
    end
  end

  // R5: every column pulse is preceded by the column setup step
  a_r5_cas_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAS && $past(st) != S_CAS) |-> $past(st) == S_CSET);
  // R10: no request is taken while refresh is pending
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !accept);
endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic [DATA_W/8-1:0] lane_en,
  input  logic [DATA_W-1:0]   bus_in,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign mask[g*8 +: 8] = {8{lane_en[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_rdata <= bus_in & mask;
    end
  end

  // R6: the valid indication is a single-cycle pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int COL_W       = 10,
  parameter int DATA_W      = 16,
  parameter int T_RP_CYC    = 5,
  parameter int T_RCD_CYC   = 2,
  parameter int T_CAS_CYC   = 2,
  parameter int T_CP_CYC    = 1,
  parameter int RAS_MAX_CYC = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic                    req_write,
  input  logic [DATA_W/8-1:0]     req_be,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic                    ref_req,
  output logic                    ref_gnt,
  output logic [ROW_W-1:0]        dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_lcas_n,
  output logic                    dram_ucas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int LANES  = DATA_W / 8;
  localparam int MARGIN = T_CAS_CYC + T_CP_CYC + 2;

  fpm_state_e st;
  logic accept, cas_last, row_hit, close_page, ras_low, col_phase;
  logic [ROW_W-1:0]  open_row, cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [LANES-1:0]  cur_be;
  logic [DATA_W-1:0] cur_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wr    <= 1'b0;
      cur_be    <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_row   <= req_addr[ADDR_W-1:COL_W];
      cur_col   <= req_addr[COL_W-1:0];
      cur_wr    <= req_write;
      cur_be    <= req_be;
      cur_wdata <= req_wdata;
    end
  end

  assign row_hit = (req_addr[ADDR_W-1:COL_W] == open_row);

  fpm_seq #(
    .T_RP_CYC (T_RP_CYC),
    .T_RCD_CYC(T_RCD_CYC),
    .T_CAS_CYC(T_CAS_CYC),
    .T_CP_CYC (T_CP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .row_hit   (row_hit),
    .close_page(close_page),
    .ref_req   (ref_req),
    .st        (st),
    .req_ready (req_ready),
    .accept    (accept),
    .cas_last  (cas_last),
    .ref_gnt   (ref_gnt)
  );

  fpm_page_track #(
    .ROW_W      (ROW_W),
    .RAS_MAX_CYC(RAS_MAX_CYC),
    .MARGIN_CYC (MARGIN)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_low   (ras_low),
    .load      (accept),
    .new_row   (req_addr[ADDR_W-1:COL_W]),
    .open_row  (open_row),
    .close_page(close_page)
  );

  fpm_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (cas_last && !cur_wr),
    .lane_en  (cur_be),
    .bus_in   (dram_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  // pin decode from registered state
  assign ras_low   = (st == S_ACT) || (st == S_CSET) || (st == S_CAS) ||
                     (st == S_CPRE) || (st == S_OPEN);
  assign col_phase = (st == S_CSET) || (st == S_CAS);

  assign dram_ras_n  = !ras_low;
  assign dram_addr   = (st == S_ACT) ? cur_row : ROW_W'(cur_col);
  assign dram_lcas_n = !((st == S_CAS) && cur_be[0]);
  assign dram_ucas_n = !((st == S_CAS) && cur_be[LANES-1]);
  assign dram_we_n   = !(col_phase && cur_wr);
  assign dram_oe_n   = !(col_phase && !cur_wr);
  assign dram_dq_oe  = col_phase && cur_wr;
  assign dram_dq_out = cur_wdata;

  // R4: early write, write enable already low before a strobe falls
  a_r4_we_early: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> $past(!dram_we_n));
  // R4: the bus is driven only with write enable low and output enable high
  a_r4_drive_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));
  // R10: bus released while granted
  a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_lcas_n && dram_ucas_n && !dram_dq_oe));
  // R2: row strobe falls with the row on the bus
  a_r2_row_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (dram_addr == cur_row));
endmodule

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
  localparam int T_RP  = 3;
  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_CP  = 1;
  localparam int RMAX  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [19:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic ref_req = 1'b0;
  logic ref_gnt;
  logic [9:0] dram_addr;
  logic dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = '0;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(
    .T_RP_CYC(T_RP), .T_RCD_CYC(T_RCD), .T_CAS_CYC(T_CAS),
    .T_CP_CYC(T_CP), .RAS_MAX_CYC(RMAX)
  ) i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ras_falls = 0;
  logic [15:0] shadow [int];
  logic [15:0] mdl [int];
  logic [15:0] exp_q [$];
  logic [9:0] exp_row = '0, exp_col = '0;
  logic exp_wr = 1'b0;
  logic [1:0] exp_be = '0;
  logic [15:0] exp_wdata = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] dflt(input int a);
    return 16'(a ^ (a >> 5) ^ 16'h3C69);
  endfunction

  function automatic logic [15:0] rd_shadow(input int a);
    return shadow.exists(a) ? shadow[a] : dflt(a);
  endfunction

  function automatic logic [15:0] rd_mdl(input int a);
    return mdl.exists(a) ? mdl[a] : dflt(a);
  endfunction

  // driver: pushes expected read data into the scoreboard queue
  task automatic do_req(input logic [19:0] a, input logic wr, input logic [1:0] be, input logic [15:0] d);
    logic [15:0] old, mrg;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_row = a[19:10]; exp_col = a[9:0]; exp_wr = wr; exp_be = be; exp_wdata = d;
    old = rd_shadow(int'(a));
    if (wr) begin
      mrg = old;
      if (be[0]) mrg[7:0] = d[7:0];
      if (be[1]) mrg[15:8] = d[15:8];
      shadow[int'(a)] = mrg;
    end else begin
      exp_q.push_back(old & {{8{be[1]}}, {8{be[0]}}});
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    int w = 0;
    while (exp_q.size() != 0 && w < 200) begin @(negedge clk); w++; end
    repeat (8) @(negedge clk);
  endtask

  // pin monitor, device model and response scoreboard
  logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
  int lo_run = 0, hi_run = 100, cas_hi = 0, since_fall = 0;
  bit page_cas = 1'b0;
  logic [9:0] m_row = '0, m_col = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit cas_fell;
      cas_fell = (!dram_lcas_n || !dram_ucas_n) && p_l && p_u;
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        m_row = dram_addr;
        chk(dram_addr == exp_row, "R2 row on bus", 32'(dram_addr), 32'(exp_row));
        chk(hi_run >= T_RP, "R5 ras precharge", 32'(hi_run), 32'(T_RP));
        lo_run = 1; since_fall = 0; page_cas = 1'b0;
      end else if (!dram_ras_n) begin
        lo_run++; since_fall++;
      end
      if (!p_ras && dram_ras_n) begin
        chk(lo_run <= RMAX, "R9 ras low limit", 32'(lo_run), 32'(RMAX));
        hi_run = 1;
      end else if (dram_ras_n) begin
        hi_run++;
      end
      if (cas_fell) begin
        m_col = dram_addr;
        chk(dram_addr == exp_col, "R2 col on bus", 32'(dram_addr), 32'(exp_col));
        chk({!dram_ucas_n, !dram_lcas_n} == exp_be, "R3 lane strobes",
            32'({!dram_ucas_n, !dram_lcas_n}), 32'(exp_be));
        chk(since_fall >= T_RCD + 1, "R5 ras to cas", 32'(since_fall), 32'(T_RCD + 1));
        if (page_cas) chk(cas_hi >= T_CP, "R5 cas precharge", 32'(cas_hi), 32'(T_CP));
        page_cas = 1'b1;
        if (exp_wr) begin
          chk(!dram_we_n && !p_we && dram_oe_n, "R4 early write", {30'd0, dram_we_n, p_we}, 32'd0);
          chk(dram_dq_oe && dram_dq_out == exp_wdata, "R4 write data", 32'(dram_dq_out), 32'(exp_wdata));
          begin
            logic [15:0] v;
            v = rd_mdl({m_row, m_col});
            if (!dram_lcas_n) v[7:0] = dram_dq_out[7:0];
            if (!dram_ucas_n) v[15:8] = dram_dq_out[15:8];
            mdl[int'({m_row, m_col})] = v;
          end
        end else begin
          chk(dram_we_n && !dram_dq_oe, "R4 read no drive", {30'd0, dram_we_n, dram_dq_oe}, 32'd2);
        end
      end
      if (dram_lcas_n && dram_ucas_n) cas_hi++; else cas_hi = 0;
      if (!dram_ras_n && !dram_oe_n) begin
        logic [15:0] v;
        v = rd_mdl({m_row, m_col});
        dram_dq_in = {dram_ucas_n ? 8'hA5 : v[15:8], dram_lcas_n ? 8'h5A : v[7:0]};
      end else begin
        dram_dq_in = 16'hBEEF;
      end
      if (ref_gnt)
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n && !dram_dq_oe && !req_ready,
            "R10 released", {27'd0, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_dq_oe, req_ready}, 32'h1C);
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", 32'(rsp_rdata), 32'd0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R6 R11 read data", 32'(rsp_rdata), 32'(e));
        end
      end
      p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0, w;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n,
        "R1 strobes high", {27'd0, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}, 32'h1F);
    chk(!dram_dq_oe && !req_ready && !rsp_valid, "R1 idle outputs",
        {29'd0, dram_dq_oe, req_ready, rsp_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    chk(!req_ready, "R1 ready after reset", 32'(req_ready), 32'd0);
    w = 0;
    while (!req_ready && w < 20) begin @(negedge clk); w++; end
    chk(w == T_RP, "R1 precharge before ready", 32'(w), 32'(T_RP));

    // R2 R7: word write then read
    do_req(20'h12345, 1'b1, 2'b11, 16'h1111);
    do_req(20'h12345, 1'b0, 2'b11, 16'h0);
    // R3: byte writes in the same row
    do_req(20'h12346, 1'b1, 2'b01, 16'hAAC1);
    do_req(20'h12346, 1'b1, 2'b10, 16'hD2BB);
    do_req(20'h12346, 1'b0, 2'b11, 16'h0);
    do_req(20'h12347, 1'b1, 2'b10, 16'h7700);
    do_req(20'h12347, 1'b0, 2'b11, 16'h0);
    // R6: byte read masks the other lane
    do_req(20'h12346, 1'b0, 2'b01, 16'h0);
    do_req(20'h12346, 1'b0, 2'b10, 16'h0);
    drain();

    // R7 R8: miss opens a row once, hits reuse it
    f0 = ras_falls;
    do_req(20'h40010, 1'b0, 2'b11, 16'h0);
    do_req(20'h40011, 1'b1, 2'b11, 16'h4242);
    do_req(20'h40011, 1'b0, 2'b11, 16'h0);
    do_req(20'h40012, 1'b0, 2'b11, 16'h0);
    drain();
    chk(ras_falls - f0 == 1, "R7 R8 row opened once", 32'(ras_falls - f0), 32'd1);

    // R8: alternating rows each reopen
    f0 = ras_falls;
    do_req(20'h80001, 1'b0, 2'b11, 16'h0);
    do_req(20'h00401, 1'b0, 2'b11, 16'h0);
    drain();
    chk(ras_falls - f0 == 2, "R8 miss reopens", 32'(ras_falls - f0), 32'd2);

    // R9: long same-row stream is split
    f0 = ras_falls;
    for (int i = 0; i < 14; i++) do_req(20'hC0000 + 20'(i), 1'b0, 2'b11, 16'h0);
    drain();
    chk(ras_falls - f0 >= 2, "R9 page split", 32'(ras_falls - f0), 32'd2);

    // R10: refresh grant closes the page
    do_req(20'h55000, 1'b0, 2'b11, 16'h0);
    @(negedge clk); ref_req = 1'b1;
    w = 0;
    while (!ref_gnt && w < 50) begin @(negedge clk); w++; end
    chk(ref_gnt == 1'b1, "R10 grant", 32'(ref_gnt), 32'd1);
    repeat (5) @(negedge clk);
    chk(!req_ready && dram_ras_n, "R10 held off", {30'd0, req_ready, dram_ras_n}, 32'd1);
    ref_req = 1'b0;
    f0 = ras_falls;
    do_req(20'h55001, 1'b0, 2'b11, 16'h0);
    drain();
    chk(ras_falls - f0 == 1, "R10 page closed", 32'(ras_falls - f0), 32'd1);

    // R11: mixed traffic over four rows
    for (int i = 0; i < 40; i++) begin
      logic [19:0] a;
      a = {8'h2A, 2'(i % 4), 10'(i % 6)};
      do_req(a, (i % 3) == 0, 2'((i % 3) + 1), 16'(i * 16'h0913));
    end
    drain();
    chk(exp_q.size() == 0, "R11 all responses", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule